// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block sits between an in-order operation queue and the issue logic of a superscalar core. Each cycle it looks at up to `NIN` decoded operations at the head of the queue, oldest first, and packs as many as fit into a dispatch group of five ordered slots. Each operation carries a class code that sets how many slots it needs and which positions it may use. The block returns the number of operations it consumed so the queue can pop them. It also registers the finished group, with a per-slot valid bit, source index, class, part number and execution-unit select.

Packing stops at the first operation that does not fit or whose valid bit is low. That operation and every younger one stay in the queue and lead the next group. The group register is held while the consumer stalls, and nothing is consumed during a stall.

Class codes: 0 simple integer, 1 floating-point, 2 load/store, 3 two-part cracked, 4 three-part cracked, 5 four-part serialising, 6 front pair (slots 1 and 2 of an empty group), 7 front single (slot 1 of an empty group), 8 branch.

Top module: `dga_top`

## Requirements
- R1: Operations are placed strictly oldest first. Placement stops at the first invalid input or the first operation that does not fit. No younger operation is placed after that point.
- R2: A class 0, 1 or 2 operation takes exactly one slot, the lowest free slot among slots 1 to 4. Its part number is 0.
- R3: A class 2 operation in slot 1 or slot 4 gets unit select 0. In slot 2 or slot 3 it gets unit select 1. Every other occupied slot gets unit select 0 in slots 1, 3 and 5, and 1 in slots 2 and 4.
- R4: A branch (class 8) always goes to slot 5 when slot 5 is still open. Any unused slots before it stay empty, and the group closes after it.
- R5: A class 3 or class 4 operation takes 2 or 3 consecutive slots. It starts at the lowest free slot and must end at or before slot 4. Its part numbers count up from 0.
- R6: A class 5 operation is placed only into an empty group. It takes slots 1 to 4 with parts 0 to 3, and the group closes after it, so not even a branch joins it.
- R7: A class 6 operation is placed only into an empty group and takes slots 1 and 2. A class 7 operation is placed only into an empty group and takes slot 1 alone. Later operations may follow either one.
- R8: `take_cnt` equals the number of operations placed in the cycle. An operation that does not fit is not counted.
- R9: A group is issued (`grp_valid` high) only if it holds at least one operation. When input 0 is valid and the group register can load, at least one operation is taken.
- R10: While `grp_valid` is high and `grp_ready` is low, `take_cnt` is 0 and every group output holds its value.
- R11: After reset, `grp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NIN | Per-entry valid, entry 0 oldest |
| in_cls | input | NIN x 4 | Class code per entry |
| take_cnt | output | 3 | Entries consumed this cycle |
| grp_ready | input | 1 | Consumer accepts the current group |
| grp_valid | output | 1 | Group register holds a group |
| slot_vld | output | 5 | Occupied slots, bit 0 is slot 1 |
| slot_idx | output | 5 x 3 | Source entry index per slot |
| slot_cls | output | 5 x 4 | Class code per slot |
| slot_part | output | 5 x 2 | Part number of a multi-slot operation |
| slot_unit | output | 5 | Unit select within the unit pair |

## Verification
A wrong fill pointer in the placement chain shows up in the same cycle as a wrong `take_cnt`. One cycle later it shows as a shifted or missing slot in the registered group, so every sweep vector exposes it within one clock. A wrong closed-group state shows as an operation sitting next to a branch or a four-part operation. A wrong unit mapping shows only on load/store slots, which is why the sweep covers every class in every position. A lost stall condition shows as a nonzero take or a changed group while `grp_ready` is low.

// File: rtl/dga_pkg.sv
package dga_pkg;
    localparam int NSLOT    = 5;
    localparam int LAST     = NSLOT - 1;
    localparam int CLSW     = 4;
    localparam int PARTW    = 2;
    localparam int IDXW     = 3;
    localparam int POSW     = 3;
    localparam logic [POSW-1:0] POS_FULL = 3'd5;

    typedef enum logic [CLSW-1:0] {
        CLS_INT    = 4'd0,
        CLS_FP     = 4'd1,
        CLS_MEM    = 4'd2,
        CLS_PAIR   = 4'd3,
        CLS_TRIO   = 4'd4,
        CLS_QUAD   = 4'd5,
        CLS_FRONT2 = 4'd6,
        CLS_SOLO1  = 4'd7,
        CLS_BRANCH = 4'd8
    } op_cls_e;

    typedef struct packed {
        logic            vld;
        logic [IDXW-1:0] idx;
        logic [CLSW-1:0] cls;
        logic [PARTW-1:0] part;
        logic            unit;
    } slot_t;

    typedef struct packed {
        logic            ok;
        logic [POSW-1:0] start;
        logic [POSW-1:0] len;
        logic [POSW-1:0] nxt;
    } place_t;

    // Placement rule for one operation given the next free slot p.
    function automatic place_t place_rule(logic [CLSW-1:0] c, logic [POSW-1:0] p);
        place_t r;
        logic   closes;
        r      = '0;
        closes = 1'b0;
        r.start = p;
        r.len   = 3'd1;
        case (c)
            CLS_INT, CLS_FP, CLS_MEM: r.ok = (p <= 3'd3);
            CLS_PAIR:   begin r.ok = (p <= 3'd2); r.len = 3'd2; end
            CLS_TRIO:   begin r.ok = (p <= 3'd1); r.len = 3'd3; end
            CLS_QUAD:   begin r.ok = (p == 3'd0); r.len = 3'd4; closes = 1'b1; end
            CLS_FRONT2: begin r.ok = (p == 3'd0); r.len = 3'd2; end
            CLS_SOLO1:  r.ok = (p == 3'd0);
            CLS_BRANCH: begin r.ok = (p <= 3'd4); r.start = 3'(LAST); closes = 1'b1; end
            default:    r.ok = 1'b0;
        endcase
        r.nxt = closes ? POS_FULL : p + r.len;
        return r;
    endfunction

    // Unit select for slot s (0-based).
    function automatic logic unit_for(logic [CLSW-1:0] c, int s);
        if (c == CLS_MEM) return (s == 1) || (s == 2);
        return s[0];
    endfunction
endpackage

// File: rtl/dga_stage.sv
module dga_stage
    import dga_pkg::*;
(
    input  logic            run_in,
    input  logic [POSW-1:0] pos_in,
    input  logic            op_valid,
    input  logic [CLSW-1:0] op_cls,
    output logic            fit,
    output logic [POSW-1:0] start,
    output logic [POSW-1:0] len,
    output logic [POSW-1:0] pos_out
);
    place_t pr;

    always_comb begin
        pr      = place_rule(op_cls, pos_in);
        fit     = run_in && op_valid && pr.ok;
        start   = pr.start;
        len     = pr.len;
        pos_out = fit ? pr.nxt : pos_in;
    end
endmodule

// File: rtl/dga_slotfill.sv
module dga_slotfill
    import dga_pkg::*;
#(
    parameter int NIN = 5
) (
    input  logic [NIN-1:0]            fit,
    input  logic [NIN-1:0][POSW-1:0]  start,
    input  logic [NIN-1:0][POSW-1:0]  len,
    input  logic [NIN-1:0][CLSW-1:0]  cls,
    output slot_t [NSLOT-1:0]         slots
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_comb begin
            slots[s] = '0;
            for (int i = 0; i < NIN; i++) begin
                if (fit[i] && (s >= int'(start[i])) && (s < int'(start[i]) + int'(len[i]))) begin
                    slots[s].vld  = 1'b1;
                    slots[s].idx  = IDXW'(i);
                    slots[s].cls  = cls[i];
                    slots[s].part = PARTW'(s - int'(start[i]));
                    slots[s].unit = unit_for(cls[i], s);
                end
            end
        end
    end
endmodule

// File: rtl/dga_top.sv
module dga_top
    import dga_pkg::*;
#(
    parameter int NIN = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NIN-1:0]              in_valid,
    input  logic [NIN-1:0][CLSW-1:0]    in_cls,
    output logic [IDXW-1:0]             take_cnt,
    input  logic                        grp_ready,
    output logic                        grp_valid,
    output logic [NSLOT-1:0]            slot_vld,
    output logic [NSLOT-1:0][IDXW-1:0]  slot_idx,
    output logic [NSLOT-1:0][CLSW-1:0]  slot_cls,
    output logic [NSLOT-1:0][PARTW-1:0] slot_part,
    output logic [NSLOT-1:0]            slot_unit
);
    localparam int CNTW = IDXW;

    logic [NIN:0]              run;
    logic [NIN:0][POSW-1:0]    pos;
    logic [NIN-1:0]            fit;
    logic [NIN-1:0][POSW-1:0]  st;
    logic [NIN-1:0][POSW-1:0]  ln;
    slot_t [NSLOT-1:0]         nxt_slots;
    slot_t [NSLOT-1:0]         grp_q;
    logic                      grp_valid_q;
    logic [CNTW-1:0]           cnt;
    logic                      load_en;

    assign run[0] = 1'b1;
    assign pos[0] = '0;

    for (genvar i = 0; i < NIN; i++) begin : g_chain
        dga_stage u_stage (
            .run_in  (run[i]),
            .pos_in  (pos[i]),
            .op_valid(in_valid[i]),
            .op_cls  (in_cls[i]),
            .fit     (fit[i]),
            .start   (st[i]),
            .len     (ln[i]),
            .pos_out (pos[i+1])
        );
        assign run[i+1] = fit[i];
    end

    dga_slotfill #(.NIN(NIN)) u_fill (
        .fit  (fit),
        .start(st),
        .len  (ln),
        .cls  (in_cls),
        .slots(nxt_slots)
    );

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NIN; i++) cnt = cnt + CNTW'(fit[i]);
    end

    assign load_en  = !grp_valid_q || grp_ready;
    assign take_cnt = load_en ? cnt : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_valid_q <= 1'b0;
            grp_q       <= '0;
        end else if (load_en) begin
            grp_valid_q <= (cnt != '0);
            grp_q       <= nxt_slots;
        end
    end

    assign grp_valid = grp_valid_q;
    for (genvar s = 0; s < NSLOT; s++) begin : g_out
        assign slot_vld[s]  = grp_q[s].vld;
        assign slot_idx[s]  = grp_q[s].idx;
        assign slot_cls[s]  = grp_q[s].cls;
        assign slot_part[s] = grp_q[s].part;
        assign slot_unit[s] = grp_q[s].unit;
    end
endmodule

// File: rtl/dga_checker.sv
module dga_checker
    import dga_pkg::*;
#(
    parameter int NIN = 5
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NIN-1:0]              in_valid,
    input logic [IDXW-1:0]             take_cnt,
    input logic                        grp_ready,
    input logic                        grp_valid,
    input logic [NSLOT-1:0]            slot_vld,
    input logic [NSLOT-1:0][CLSW-1:0]  slot_cls,
    input logic [NSLOT-1:0]            slot_unit
);
    AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(take_cnt) <= $countones(in_valid)); // R8

    AST_BRANCH_LAST: assert property (@(posedge clk) disable iff (rst)
        grp_valid && slot_vld[LAST] |-> slot_cls[LAST] == CLS_BRANCH); // R4

    AST_QUAD_ALONE: assert property (@(posedge clk) disable iff (rst)
        grp_valid && slot_vld[0] && slot_cls[0] == CLS_QUAD |-> !slot_vld[LAST]); // R6

    AST_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        grp_valid |-> slot_vld != '0); // R9

    AST_TAKE_ISSUES: assert property (@(posedge clk) disable iff (rst)
        take_cnt != '0 |=> grp_valid); // R9

    AST_STALL_NOTAKE: assert property (@(posedge clk) disable iff (rst)
        grp_valid && !grp_ready |-> take_cnt == '0); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        grp_valid && !grp_ready |=> grp_valid && $stable(slot_vld) && $stable(slot_cls)); // R10

    for (genvar s = 0; s < NSLOT - 1; s++) begin : g_mem
        AST_MEM_UNIT: assert property (@(posedge clk) disable iff (rst)
            grp_valid && slot_vld[s] && slot_cls[s] == CLS_MEM
            |-> slot_unit[s] == ((s == 1) || (s == 2))); // R3
    end
endmodule

bind dga_top dga_checker #(.NIN(NIN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .take_cnt (take_cnt),
    .grp_ready(grp_ready),
    .grp_valid(grp_valid),
    .slot_vld (slot_vld),
    .slot_cls (slot_cls),
    .slot_unit(slot_unit)
);

// File: tb/sim_dga_top.sv
`timescale 1ns/1ps
module sim_dga_top;
    import dga_pkg::*;
    localparam int NIN = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NIN-1:0]              in_valid = '0;
    logic [NIN-1:0][CLSW-1:0]    in_cls = '0;
    logic [IDXW-1:0]             take_cnt;
    logic                        grp_ready = 1'b1;
    logic                        grp_valid;
    logic [NSLOT-1:0]            slot_vld;
    logic [NSLOT-1:0][IDXW-1:0]  slot_idx;
    logic [NSLOT-1:0][CLSW-1:0]  slot_cls;
    logic [NSLOT-1:0][PARTW-1:0] slot_part;
    logic [NSLOT-1:0]            slot_unit;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int e_take;
    int e_vld[NSLOT], e_idx[NSLOT], e_cls[NSLOT], e_part[NSLOT], e_unit[NSLOT];

    always #2 clk = ~clk;

    dga_top #(.NIN(NIN)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
        .take_cnt(take_cnt), .grp_ready(grp_ready), .grp_valid(grp_valid),
        .slot_vld(slot_vld), .slot_idx(slot_idx), .slot_cls(slot_cls),
        .slot_part(slot_part), .slot_unit(slot_unit)
    );

    // Independent model of the requirements.
    task automatic model(input logic [NIN-1:0] v, input int c[NIN]);
        int p;
        bit closed;
        p = 0; closed = 0; e_take = 0;
        for (int s = 0; s < NSLOT; s++) begin
            e_vld[s] = 0; e_idx[s] = 0; e_cls[s] = 0; e_part[s] = 0; e_unit[s] = 0;
        end
        for (int i = 0; i < NIN; i++) begin
            int first, width;
            bit ok;
            if (!v[i] || closed) break;
            first = p; width = 1; ok = 0;
            if (c[i] <= 2)       ok = (p + 1 <= 4);              // R2
            else if (c[i] == 3) begin width = 2; ok = (p + 2 <= 4); end // R5
            else if (c[i] == 4) begin width = 3; ok = (p + 3 <= 4); end // R5
            else if (c[i] == 5) begin width = 4; ok = (p == 0); end     // R6
            else if (c[i] == 6) begin width = 2; ok = (p == 0); end     // R7
            else if (c[i] == 7) ok = (p == 0);                          // R7
            else if (c[i] == 8) begin first = 4; ok = (p <= 4); end     // R4
            if (!ok) break;
            for (int k = 0; k < width; k++) begin
                int s;
                s = first + k;
                e_vld[s] = 1; e_idx[s] = i; e_cls[s] = c[i]; e_part[s] = k;
                e_unit[s] = (c[i] == 2) ? ((s == 1 || s == 2) ? 1 : 0) : (s % 2);
            end
            p = first + width;
            if (c[i] == 5 || c[i] == 8) closed = 1;
            e_take++;
        end
    endtask

    function automatic string tag_of(int c);
        case (c)
            2: return "R3";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            8: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check_take(input string tag);
        total++;
        if (int'(take_cnt) != e_take) begin
            bad++;
            $display("FAIL %s take_cnt actual=%0d expected=%0d", tag, take_cnt, e_take);
        end
    endtask

    task automatic check_group();
        total++;
        if (grp_valid !== (e_take != 0)) begin
            bad++;
            $display("FAIL R9 grp_valid actual=%0b expected=%0b", grp_valid, e_take != 0);
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (int'(slot_vld[s]) != e_vld[s] ||
                (e_vld[s] == 1 && (int'(slot_idx[s]) != e_idx[s] || int'(slot_cls[s]) != e_cls[s] ||
                 int'(slot_part[s]) != e_part[s] || int'(slot_unit[s]) != e_unit[s]))) begin
                bad++;
                $display("FAIL %s R1 slot%0d actual=v%0b i%0d c%0d p%0d u%0b expected=v%0d i%0d c%0d p%0d u%0d",
                         tag_of(e_cls[s]), s + 1, slot_vld[s], slot_idx[s], slot_cls[s], slot_part[s],
                         slot_unit[s], e_vld[s], e_idx[s], e_cls[s], e_part[s], e_unit[s]);
                break;
            end
        end
    endtask

    // Called at a negedge; returns at the next negedge after checking.
    task automatic run_vec(input logic [NIN-1:0] v, input int c[NIN]);
        in_valid = v;
        for (int i = 0; i < NIN; i++) in_cls[i] = CLSW'(c[i]);
        model(v, c);
        #1;
        check_take("R8");
        @(negedge clk);
        check_group();
    endtask

    initial begin
        int c[NIN];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        total++;
        if (grp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R11 grp_valid actual=%0b expected=0", grp_valid);
        end

        // Nothing valid: no group. R9
        for (int i = 0; i < NIN; i++) c[i] = 0;
        run_vec('0, c);

        // Exhaustive sweep over all class sequences. R1 R2 R3 R4 R5 R6 R7 R8
        for (int code = 0; code < 59049; code++) begin
            int r;
            r = code;
            for (int i = 0; i < NIN; i++) begin c[i] = r % 9; r = r / 9; end
            run_vec('1, c);
        end

        // Valid-mask patterns: prefixes and holes. R1
        for (int m = 0; m < 32; m++) begin
            for (int i = 0; i < NIN; i++) c[i] = (i + m) % 3;
            run_vec(NIN'(m), c);
        end

        // Stall: group held, nothing taken. R10
        for (int i = 0; i < NIN; i++) c[i] = 2;
        run_vec('1, c);
        grp_ready = 1'b0;
        for (int i = 0; i < NIN; i++) c[i] = 8;
        in_valid = '1;
        for (int i = 0; i < NIN; i++) in_cls[i] = CLSW'(c[i]);
        #1;
        total++;
        if (take_cnt != '0) begin
            bad++;
            $display("FAIL R10 take_cnt actual=%0d expected=0", take_cnt);
        end
        @(negedge clk);
        for (int i = 0; i < NIN; i++) c[i] = 2;
        model('1, c);
        check_group();
        grp_ready = 1'b1;
        for (int i = 0; i < NIN; i++) c[i] = 8;
        run_vec('1, c);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule